// File: doc/BRIEF.md
# EEPROM Byte-Write Host Controller

This block sits on the host side of a parallel, SRAM-style EEPROM that times its own writes. It takes one command at a time over a valid/ready handshake. A command is either a byte write (address plus data) or a byte read. The block then sequences the memory's chip-select, output-enable and write-strobe pins, and drives or releases the data bus, so that each phase lasts a number of clock cycles set by a parameter.

A byte write has three phases: address and data setup, a low write-strobe pulse, and a hold phase that keeps the data driven past the strobe's rising edge. The block then waits for the device to finish. A per-command configuration bit selects how completion is found. In the first method, the block reads the target byte again and again, with idle gaps between reads, until the top data bit matches the written one. In the second method, the block watches the open-drain busy line through a synchronizer. Either way, one final read compares the whole byte with the written value. A watchdog stops the wait if the device never finishes.

Each command ends with a one-cycle `done` pulse and the byte that was read. A timeout and a verify mismatch are reported as flags, and both flags stay set until the next command is accepted.

Top module: `eeprom_wr_host`

## Requirements
- R1: After reset, `cmd_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe`, `done`, `err_timeout` and `err_verify` are 0. `cmd_ready` is 1 only while the controller is idle, and it falls in the cycle after a command is accepted.
- R2: For a write, the controller holds `mem_ce_n`=0 and `mem_oe_n`=1 with the bus driven and `mem_we_n`=1 for exactly SETUP_CYC cycles. It then holds `mem_we_n`=0 for exactly STROBE_CYC cycles. The address stays stable throughout.
- R3: On the cycle `mem_we_n` rises, `mem_dq_out` equals the command's write data and `mem_dq_oe`=1. The bus stays driven, with `mem_ce_n`=0 and `mem_oe_n`=1, for exactly HOLD_CYC cycles counted from that rise.
- R4: `mem_dq_oe`=1 and `mem_oe_n`=0 never occur in the same cycle.
- R5: In polling mode (`cfg_use_rdy`=0), the controller releases the chip for exactly GAP_CYC cycles before each read that checks for completion. It treats the write as finished once the read's bit 7 equals bit 7 of the written data.
- R6: In busy-line mode (`cfg_use_rdy`=1), `mem_rdy_n` (0 = busy) passes through a two-stage synchronizer. The controller issues no read to the device while the line shows busy.
- R7: After completion, the controller makes one full-byte read. `rd_data` returns that byte. `err_verify` is 1 if the byte differs from the write data, and 0 otherwise.
- R8: A read command raises `done` exactly READ_CYC+1 cycles after acceptance, with `rd_data` equal to the stored byte. `mem_we_n` stays 1 during the read.
- R9: If completion is not seen within TIMEOUT_CYC cycles of waiting (WRITE_MAX_CYC × TIMEOUT_MULT), the controller becomes idle again, with `err_timeout`=1 and no `done` pulse. `cmd_ready` returns exactly SETUP_CYC+STROBE_CYC+HOLD_CYC+TIMEOUT_CYC+1 cycles after acceptance.
- R10: `err_timeout` and `err_verify` hold their value until the next accepted command, and that acceptance clears them.
- R11: `done` is high for exactly one cycle at the end of each completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command taken when valid |
| cmd_write | input | 1 | 1 = byte write, 0 = byte read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write data |
| cfg_use_rdy | input | 1 | Completion method, captured with the command: 1 = busy line, 0 = bit-7 polling |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte from the last read or the verify read |
| err_timeout | output | 1 | Sticky: write did not finish in time |
| err_verify | output | 1 | Sticky: verify read differed from write data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data to the memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_rdy_n | input | 1 | Open-drain ready line, 0 while the device writes |

## Verification
A read command's `done` and `rd_data` are due READ_CYC+1 cycles after the accepting edge. A timed-out write's `cmd_ready` and `err_timeout` are due SETUP_CYC+STROBE_CYC+HOLD_CYC+TIMEOUT_CYC+1 cycles after that edge, and the bench counts falling edges from acceptance and checks against those exact numbers. Setup, strobe, hold and poll-gap widths are measured by a bench memory model that counts falling-edge samples of the pins within each phase. Polled-write completion depends on a random busy length, so there the bench checks the done cycle itself: the flags and `rd_data` are read on that cycle, and `done` is read as low on the next one.

// File: rtl/ehc_pkg.sv
package ehc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_POLL_READ,
    ST_POLL_GAP,
    ST_READ,
    ST_DONE
  } ehc_state_e;
endpackage

// File: rtl/ehc_phase_timer.sv
// Down-counter for phase lengths; expired when it reaches zero.
module ehc_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ehc_sync.sv
// Multi-stage synchronizer; reset value is "busy" (0).
module ehc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/ehc_watchdog.sv
// Counts cycles while run is high; clears when run drops.
module ehc_watchdog #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                          cnt_d = '0;
    else if (cnt_q != CW'(LIMIT - 1))  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/eeprom_wr_host.sv
module eeprom_wr_host
  import ehc_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 2,
  parameter int STROBE_CYC    = 3,
  parameter int HOLD_CYC      = 2,
  parameter int GAP_CYC       = 4,
  parameter int READ_CYC      = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int WRITE_MAX_CYC = 50000,
  parameter int TIMEOUT_MULT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cfg_use_rdy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_timeout,
  output logic              err_verify,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_rdy_n
);
  localparam int TIMEOUT_CYC = WRITE_MAX_CYC * TIMEOUT_MULT;
  localparam int TMR_W       = $clog2(SETUP_CYC + STROBE_CYC + HOLD_CYC + GAP_CYC + READ_CYC + 1);
  localparam int FLAG_BIT    = DATA_W - 1;

  ehc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              is_wr_q;
  logic              use_rdy_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              err_to_q;
  logic              err_vf_q;

  logic              accept;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              wd_run;
  logic              wd_exp;
  logic              rdy_s;
  logic              rd_cap;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign wd_run    = (state_q == ST_POLL_GAP) || (state_q == ST_POLL_READ);
  assign rd_cap    = (state_q == ST_READ) && tmr_exp;

  ehc_phase_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  ehc_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wd_run),
    .expired (wd_exp)
  );

  ehc_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mem_rdy_n),
    .q     (rdy_s)
  );

  // Next-state and phase-timer load decode
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) state_d = cmd_write ? ST_SETUP : ST_READ;
      end
      ST_SETUP: begin
        if (tmr_exp) state_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (tmr_exp) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (tmr_exp) state_d = ST_POLL_GAP;
      end
      ST_POLL_GAP: begin
        if (wd_exp) begin
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          if (!use_rdy_q)  state_d  = ST_POLL_READ;
          else if (rdy_s)  state_d  = ST_READ;
          else             tmr_load = 1'b1;
        end
      end
      ST_POLL_READ: begin
        if (wd_exp) begin
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          state_d = (mem_dq_in[FLAG_BIT] == wdata_q[FLAG_BIT]) ? ST_READ : ST_POLL_GAP;
        end
      end
      ST_READ: begin
        if (tmr_exp) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (state_d != state_q) tmr_load = 1'b1;

    unique case (state_d)
      ST_SETUP:     tmr_val = TMR_W'(SETUP_CYC - 1);
      ST_STROBE:    tmr_val = TMR_W'(STROBE_CYC - 1);
      ST_HOLD:      tmr_val = TMR_W'(HOLD_CYC - 1);
      ST_POLL_GAP:  tmr_val = TMR_W'(GAP_CYC - 1);
      ST_POLL_READ: tmr_val = TMR_W'(READ_CYC - 1);
      ST_READ:      tmr_val = TMR_W'(READ_CYC - 1);
      default:      tmr_val = '0;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Command capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      is_wr_q   <= 1'b0;
      use_rdy_q <= 1'b0;
    end else if (accept) begin
      addr_q    <= cmd_addr;
      wdata_q   <= cmd_wdata;
      is_wr_q   <= cmd_write;
      use_rdy_q <= cfg_use_rdy;
    end
  end

  // Read data capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data_q <= '0;
    else if (rd_cap) rd_data_q <= mem_dq_in;
  end

  // Sticky error flags, cleared by the next accepted command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_to_q <= 1'b0;
      err_vf_q <= 1'b0;
    end else if (accept) begin
      err_to_q <= 1'b0;
      err_vf_q <= 1'b0;
    end else begin
      if (wd_exp)                                       err_to_q <= 1'b1;
      if (rd_cap && is_wr_q && (mem_dq_in != wdata_q))  err_vf_q <= 1'b1;
    end
  end

  // Pin decode from state
  always_comb begin
    mem_ce_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_dq_oe = 1'b0;
    unique case (state_q)
      ST_SETUP, ST_HOLD: begin
        mem_ce_n  = 1'b0;
        mem_dq_oe = 1'b1;
      end
      ST_STROBE: begin
        mem_ce_n  = 1'b0;
        mem_we_n  = 1'b0;
        mem_dq_oe = 1'b1;
      end
      ST_POLL_READ, ST_READ: begin
        mem_ce_n = 1'b0;
        mem_oe_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_addr    = addr_q;
  assign mem_dq_out  = wdata_q;
  assign done        = (state_q == ST_DONE);
  assign rd_data     = rd_data_q;
  assign err_timeout = err_to_q;
  assign err_verify  = err_vf_q;
endmodule

// File: rtl/ehc_checker.sv
module ehc_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              done,
  input logic              err_timeout,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  // R1: while ready, the memory is deselected and the bus released
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  // R1: an accepted command drops ready on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2: strobe only with chip selected, outputs off, bus driven
  p_strobe_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R2: address stable while strobe is low
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  // R3: data unchanged and driven across the strobe rising edge
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_dq_out) && mem_dq_oe));

  // R4: never drive the bus with the memory outputs on
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a timeout does not come with a done pulse
  p_timeout_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> !done);

  // R10: flag holds until a command is accepted
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && !(cmd_valid && cmd_ready)) |=> err_timeout);
endmodule

bind eeprom_wr_host ehc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .done        (done),
  .err_timeout (err_timeout),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dq_out  (mem_dq_out),
  .mem_dq_oe   (mem_dq_oe)
);

// File: tb/eeprom_wr_host_tb.sv
module eeprom_wr_host_tb;
  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int SETUP = 2;
  localparam int STRB  = 3;
  localparam int HOLD  = 2;
  localparam int GAP   = 4;
  localparam int RDC   = 3;
  localparam int WMAX  = 100;
  localparam int TMUL  = 2;
  localparam int TMO   = WMAX * TMUL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cfg_use_rdy = 1'b0;
  logic          cmd_ready, done, err_timeout, err_verify;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic          mem_rdy_n;

  always #2 clk = ~clk;  // 250 MHz

  eeprom_wr_host #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .STROBE_CYC(STRB), .HOLD_CYC(HOLD),
    .GAP_CYC(GAP), .READ_CYC(RDC), .SYNC_STAGES(2), .WRITE_MAX_CYC(WMAX), .TIMEOUT_MULT(TMUL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cfg_use_rdy(cfg_use_rdy), .done(done), .rd_data(rd_data),
    .err_timeout(err_timeout), .err_verify(err_verify), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_rdy_n(mem_rdy_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_byte(input int a);
    return DW'(a * 7 + 3) ^ 8'hA5;
  endfunction

  function automatic int exp_read_lat();
    return RDC + 1;
  endfunction

  function automatic int exp_tmo_lat();
    return SETUP + STRB + HOLD + TMO + 1;
  endfunction

  // ---------------- memory model (sampled at falling edges) ----------------
  logic [DW-1:0] mdl_mem [0:DEPTH-1];
  logic [DW-1:0] exp_mem [0:DEPTH-1];
  logic [DW-1:0] mdl_last = '0;
  int  busy_cnt = 0;
  int  busy_len = 10;
  bit  stuck = 0;
  bit  corrupt = 0;
  int  pre_cnt = 0, low_cnt = 0, post_cnt = 0, gap_run = 0;
  bit  in_post = 0, gap_chk = 0, poll_mode = 0;
  int  reads_in_busy = 0;
  logic prev_we = 1'b1;
  logic [DW-1:0] exp_wdata = '0;
  logic mdl_busy;

  assign mdl_busy  = (busy_cnt != 0) || stuck;
  assign mem_rdy_n = !mdl_busy;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n)
                   ? (mdl_busy ? {~mdl_last[DW-1], 7'h2A} : mdl_mem[mem_addr]) : '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R4 bus contention", 1, 0);
      if (!mem_ce_n && !mem_oe_n && mdl_busy) reads_in_busy++;
      if (cmd_ready) gap_chk = 0;
      // poll-gap width (R5)
      if (mem_ce_n) gap_run++;
      else begin
        if (gap_chk && poll_mode && gap_run > 0) check(gap_run == GAP, "R5 poll gap", gap_run, GAP);
        gap_run = 0;
      end
      if (busy_cnt > 0) busy_cnt--;
      if (!prev_we && mem_we_n) begin
        check(pre_cnt == SETUP, "R2 setup cycles", pre_cnt, SETUP);
        check(low_cnt == STRB, "R2 strobe cycles", low_cnt, STRB);
        check(mem_dq_oe && mem_dq_out == exp_wdata, "R3 data at strobe rise", int'(mem_dq_out), int'(exp_wdata));
        mdl_mem[mem_addr] <= corrupt ? (mem_dq_out ^ 8'h01) : mem_dq_out;
        mdl_last = mem_dq_out;
        busy_cnt = busy_len;
        in_post  = 1;
        post_cnt = 1;
        gap_chk  = 1;
        low_cnt  = 0;
      end else if (mem_ce_n) begin
        if (in_post) begin
          check(post_cnt == HOLD, "R3 hold cycles", post_cnt, HOLD);
          in_post = 0;
        end
        pre_cnt = 0;
        low_cnt = 0;
      end else if (!mem_we_n) begin
        low_cnt++;
      end else if (mem_oe_n && mem_dq_oe && !in_post) begin
        pre_cnt++;
      end else if (in_post) begin
        post_cnt++;
      end
      prev_we = mem_we_n;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- command driver ----------------
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit m, output int lat, output bit got_done);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    exp_wdata   = d;
    poll_mode   = !m;
    cmd_valid   = 1'b1;
    cmd_write   = wr;
    cmd_addr    = a;
    cmd_wdata   = d;
    cfg_use_rdy = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!cmd_ready, "R1 ready low after accept", int'(cmd_ready), 0);
    lat = 1;
    got_done = 0;
    while (lat < 5000) begin
      if (done) begin
        got_done = 1;
        break;
      end
      if (cmd_ready) break;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    int lat;
    bit gd;
    bit saw_we;
    issue(1'b0, a, '0, 1'b0, lat, gd);
    check(gd && lat == exp_read_lat(), {tag, " R8 read latency"}, lat, exp_read_lat());
    check(rd_data == exp_mem[a], {tag, " R8 read data"}, int'(rd_data), int'(exp_mem[a]));
    saw_we = !mem_we_n;
    check(!saw_we, {tag, " R8 no strobe on read"}, int'(saw_we), 0);
    @(negedge clk);
    check(!done, {tag, " R11 done one cycle"}, int'(done), 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit m, input string tag);
    int lat;
    bit gd;
    issue(1'b1, a, d, m, lat, gd);
    exp_mem[a] = corrupt ? (d ^ 8'h01) : d;
    check(gd, {tag, " R5/R6 write completes"}, int'(gd), 1);
    check(!err_timeout, {tag, " R9 no timeout"}, int'(err_timeout), 0);
    check(err_verify == corrupt, {tag, " R7 verify flag"}, int'(err_verify), int'(corrupt));
    check(rd_data == exp_mem[a], {tag, " R7 verify byte"}, int'(rd_data), int'(exp_mem[a]));
    @(negedge clk);
    check(!done, {tag, " R11 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    int lat;
    bit gd;
    for (int i = 0; i < DEPTH; i++) begin
      mdl_mem[i] = init_byte(i);
      exp_mem[i] = init_byte(i);
    end
    void'($urandom(32'h5EED_0017));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cmd_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done
          && !err_timeout && !err_verify, "R1 reset state", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_ready, "R1 idle ready", int'(cmd_ready), 1);

    // R8 directed reads of preset contents
    do_read(11'h000, "first");
    do_read(11'h7FF, "last");

    // R5 polled write with a long busy time
    busy_len = 40;
    reads_in_busy = 0;
    do_write(11'h123, 8'h80, 1'b0, "poll");
    check(reads_in_busy > 0, "R5 polled during busy", reads_in_busy, 1);
    do_read(11'h123, "poll readback");

    // R6 busy-line write
    busy_len = 30;
    reads_in_busy = 0;
    do_write(11'h456, 8'h3C, 1'b1, "rdy");
    check(reads_in_busy == 0, "R6 no read while busy", reads_in_busy, 0);
    do_read(11'h456, "rdy readback");

    // R7 verify mismatch, R10 cleared by next accept
    corrupt = 1;
    busy_len = 12;
    do_write(11'h010, 8'hC3, 1'b0, "corrupt");
    corrupt = 0;
    repeat (3) @(negedge clk);
    check(err_verify, "R10 verify flag holds", int'(err_verify), 1);
    issue(1'b0, 11'h010, '0, 1'b0, lat, gd);
    check(!err_verify, "R10 verify flag cleared", int'(err_verify), 0);
    check(rd_data == exp_mem[11'h010], "R8 corrupted byte read", int'(rd_data), int'(exp_mem[11'h010]));

    // R9 timeout in both modes
    for (int m = 0; m < 2; m++) begin
      stuck = 1;
      issue(1'b1, 11'h200, 8'h5A, m[0], lat, gd);
      exp_mem[11'h200] = 8'h5A;
      check(!gd, "R9 no done on timeout", int'(gd), 0);
      check(lat == exp_tmo_lat(), "R9 timeout latency", lat, exp_tmo_lat());
      check(err_timeout, "R9 timeout flag", int'(err_timeout), 1);
      repeat (5) @(negedge clk);
      check(err_timeout, "R10 timeout flag holds", int'(err_timeout), 1);
      stuck = 0;
      busy_cnt = 0;
      issue(1'b0, 11'h200, '0, 1'b0, lat, gd);
      check(!err_timeout, "R10 timeout flag cleared", int'(err_timeout), 0);
      check(rd_data == 8'h5A, "R8 read after timeout", int'(rd_data), 8'h5A);
    end

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, DEPTH - 1));
      d = DW'($urandom);
      busy_len = $urandom_range(3, 80);
      if ($urandom_range(0, 1) == 1) do_write(a, d, 1'(($urandom_range(0, 1))), "rand");
      else do_read(a, "rand");
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule